// File: doc/BRIEF.md
# Bus Loopback Test Register

This block is a single 16-bit register on a simple parallel processor bus. Software uses it to confirm that every address line and every data line of the peripheral reaches the chip intact. The register sits at one fixed address, 0xC7 by default. A write to that address stores the full data word. A later read at the same address returns that word. Walking-ones, alternating or other data patterns therefore prove the data lines.

Every write to any other address also has an effect on this register. The register takes a snapshot of that write's 8-bit address into its upper byte and sets its lower byte to zero. Software can write to an arbitrary address and then read back 0xC7 to see which address the bus actually carried. One register thus tests both buses.

Other registers may share the decoded write addresses, but they lie outside this block. The bidirectional data bus is split into a write-data input, a read-data output and an output-enable flag that drives the pad.

Top module: `lbt_bus_loopback`

## Requirements
- R1: With reset high at a clock edge, the register becomes 0x0000. Until it is next written, a read at 0xC7 returns 0x0000.
- R2: A clock edge with the write strobe high and address 0xC7 loads all 16 bits of write data into the register. The patterns 0x5555 and 0xAAAA read back unchanged.
- R3: A clock edge with the write strobe high and any address other than 0xC7 sets the register to {address, 8'h00}. The write address goes in bits 15:8, bits 7:0 become zero, and the write data is ignored.
- R4: While the read strobe is high and the address is 0xC7, the read data equals the stored register in the same cycle, and the output enable is high. No clock edge is needed for this.
- R5: While the read strobe is low or the address is not 0xC7, the read data is 0x0000 and the output enable is low.
- R6: A clock edge with the write strobe low leaves the register unchanged, whatever the address, data and read strobe are.
- R7: When a read and a write to 0xC7 happen in the same cycle, the read returns the value from before the write. The new value is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; writes are taken on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | 8 | Bus address, shared by reads and writes |
| bus_wdata_i | input | 16 | Write data from the bus |
| bus_wr_i | input | 1 | Write strobe, active high |
| bus_rd_i | input | 1 | Read strobe, active high |
| bus_rdata_o | output | 16 | Read data; zero when this register is not selected |
| bus_rdata_oe_o | output | 1 | High while this register drives the data bus |

## Verification
The assertions assume that the strobes and the address are known at every rising clock edge once reset is released. They also assume that the write-data input is known whenever a write to 0xC7 occurs. The bench meets these assumptions by driving every input from a known value on the falling edge and never leaving a strobe undefined. It allows read and write strobes to overlap only in the deliberate same-cycle case of R7. Each address is visited in turn so that every upper-byte snapshot value is produced.

// File: rtl/lbt_pkg.sv
package lbt_pkg;

    localparam int unsigned LBT_ADDR_W    = 8;
    localparam int unsigned LBT_DATA_W    = 16;
    localparam logic [LBT_ADDR_W-1:0] LBT_SELF_ADDR = 8'hC7;

    // What a clock edge does to the stored word.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'b00,
        ACT_LOAD = 2'b01,
        ACT_SNAP = 2'b10
    } lbt_act_e;

    typedef struct packed {
        lbt_act_e act;
        logic     rd_hit;
    } lbt_dec_t;

    // Classify one bus cycle.
    function automatic lbt_dec_t lbt_classify(input logic wr, input logic rd,
                                              input logic sel);
        lbt_dec_t d;
        d.rd_hit = rd & sel;
        if (!wr)
            d.act = ACT_HOLD;
        else if (sel)
            d.act = ACT_LOAD;
        else
            d.act = ACT_SNAP;
        return d;
    endfunction

endpackage

// File: rtl/lbt_decode.sv
module lbt_decode
    import lbt_pkg::*;
#(
    parameter int unsigned             ADDR_W    = LBT_ADDR_W,
    parameter logic [ADDR_W-1:0]       SELF_ADDR = LBT_SELF_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output lbt_dec_t          dec_o
);

    logic sel;
    assign sel   = (addr_i == SELF_ADDR);
    assign dec_o = lbt_classify(wr_i, rd_i, sel);

    // A write cycle must pick exactly one of load or snapshot (R2, R3).
    assert_write_kind_R2: assert property (@(posedge clk) disable iff (rst)
        wr_i |-> $onehot({dec_o.act == ACT_LOAD, dec_o.act == ACT_SNAP}));

    // No write strobe means no update action (R6).
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !wr_i |-> (dec_o.act == ACT_HOLD));

endmodule

// File: rtl/lbt_store.sv
module lbt_store
    import lbt_pkg::*;
#(
    parameter int unsigned ADDR_W = LBT_ADDR_W,
    parameter int unsigned DATA_W = LBT_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  lbt_act_e          act_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] q_o
);

    localparam int unsigned LOW_W = DATA_W - ADDR_W;

    logic [DATA_W-1:0] q_r;
    logic [DATA_W-1:0] snap_word;

    generate
        if (LOW_W > 0) begin : g_pad
            assign snap_word = {addr_i, {LOW_W{1'b0}}};
        end else begin : g_nopad
            assign snap_word = addr_i[ADDR_W-1 -: DATA_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else begin
            unique case (act_i)
                ACT_LOAD: q_r <= wdata_i;
                ACT_SNAP: q_r <= snap_word;
                default:  q_r <= q_r;
            endcase
        end
    end

    assign q_o = q_r;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (q_o == '0));

    assert_load_word_R2: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_LOAD) |=> (q_o == $past(wdata_i)));

    assert_snap_high_R3: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_SNAP) |=> (q_o[DATA_W-1 -: ADDR_W] == $past(addr_i)));

    assert_snap_low_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_SNAP) |=> (q_o[LOW_W-1:0] == '0));

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_HOLD) |=> $stable(q_o));

endmodule

// File: rtl/lbt_readmux.sv
module lbt_readmux #(
    parameter int unsigned DATA_W = lbt_pkg::LBT_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_i,
    input  logic [DATA_W-1:0] q_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              oe_o
);

    always_comb begin
        rdata_o = '0;
        oe_o    = 1'b0;
        if (hit_i) begin
            rdata_o = q_i;
            oe_o    = 1'b1;
        end
    end

    assert_read_tracks_R4: assert property (@(posedge clk) disable iff (rst)
        hit_i |-> (oe_o && rdata_o == q_i));

    assert_quiet_bus_R5: assert property (@(posedge clk) disable iff (rst)
        !hit_i |-> (!oe_o && rdata_o == '0));

endmodule

// File: rtl/lbt_bus_loopback.sv
module lbt_bus_loopback
    import lbt_pkg::*;
#(
    parameter int unsigned       ADDR_W    = LBT_ADDR_W,
    parameter int unsigned       DATA_W    = LBT_DATA_W,
    parameter logic [ADDR_W-1:0] SELF_ADDR = LBT_SELF_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_rdata_oe_o
);

    lbt_dec_t          dec;
    logic [DATA_W-1:0] stored;

    lbt_decode #(.ADDR_W(ADDR_W), .SELF_ADDR(SELF_ADDR)) u_decode (
        .clk    (clk),
        .rst    (rst),
        .addr_i (bus_addr_i),
        .wr_i   (bus_wr_i),
        .rd_i   (bus_rd_i),
        .dec_o  (dec)
    );

    lbt_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .act_i   (dec.act),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .q_o     (stored)
    );

    lbt_readmux #(.DATA_W(DATA_W)) u_readmux (
        .clk     (clk),
        .rst     (rst),
        .hit_i   (dec.rd_hit),
        .q_i     (stored),
        .rdata_o (bus_rdata_o),
        .oe_o    (bus_rdata_oe_o)
    );

    // A read during a write to this register returns the earlier word (R7).
    assert_read_old_R7: assert property (@(posedge clk) disable iff (rst)
        (dec.rd_hit && dec.act == ACT_LOAD) |=>
            ($past(bus_rdata_o) == $past(stored)));

endmodule

// File: tb/lbt_bus_loopback_tb_top.sv
module lbt_bus_loopback_tb_top;

    localparam logic [7:0] SELF = 8'hC7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] rdata;
    logic        oe;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    lbt_bus_loopback dut_i (
        .clk            (clk),
        .rst            (rst),
        .bus_addr_i     (addr),
        .bus_wdata_i    (wdata),
        .bus_wr_i       (wr),
        .bus_rd_i       (rd),
        .bus_rdata_o    (rdata),
        .bus_rdata_oe_o (oe)
    );

    task automatic check(input string req, input logic [15:0] got,
                         input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    // Read at 0xC7 with the strobe high; data and enable are checked.
    task automatic read_self(input string req, input logic [15:0] exp);
        @(negedge clk);
        addr = SELF; rd = 1'b1;
        #1;
        check(req, rdata, exp);
        check(req, {15'd0, oe}, 16'd1);
        rd = 1'b0;
    endtask

    initial begin
        logic [15:0] d;
        logic [15:0] exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        read_self("R1", 16'h0000);

        // R2: data patterns
        bus_write(SELF, 16'h5555); read_self("R2", 16'h5555);
        bus_write(SELF, 16'hAAAA); read_self("R2", 16'hAAAA);

        // R2/R3: sweep every address
        for (int a = 0; a < 256; a++) begin
            d = 16'(a * 257) ^ 16'h3C5A;
            exp = (8'(a) == SELF) ? d : {8'(a), 8'h00};
            bus_write(8'(a), d);
            read_self((8'(a) == SELF) ? "R2" : "R3", exp);
        end

        // R3: address bus test pair
        bus_write(8'h55, 16'hFFFF); read_self("R3", 16'h5500);
        bus_write(8'hAA, 16'hFFFF); read_self("R3", 16'hAA00);

        // R5: reads elsewhere or with strobe low stay quiet
        bus_write(SELF, 16'h1234);
        for (int a = 0; a < 256; a += 17) begin
            @(negedge clk);
            addr = 8'(a); rd = (8'(a) != SELF);
            #1;
            check("R5", rdata, 16'h0000);
            check("R5", {15'd0, oe}, 16'd0);
            rd = 1'b0;
        end
        @(negedge clk);
        addr = SELF; rd = 1'b0; #1;
        check("R5", rdata, 16'h0000);
        check("R5", {15'd0, oe}, 16'd0);

        // R6: no write strobe, varied address/data, register unchanged
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            addr = 8'(k * 37); wdata = 16'(k * 4099); wr = 1'b0; rd = k[0];
        end
        rd = 1'b0;
        read_self("R6", 16'h1234);

        // R7: read and write to 0xC7 in the same cycle
        @(negedge clk);
        addr = SELF; wdata = 16'hBEEF; wr = 1'b1; rd = 1'b1;
        #1;
        check("R7", rdata, 16'h1234);
        @(negedge clk);
        wr = 1'b0;
        #1;
        check("R7", rdata, 16'hBEEF);
        rd = 1'b0;

        // R1: reset after data held
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        read_self("R1", 16'h0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule